// File: doc/BRIEF.md
# Per-CPU Two-Channel Inter-Processor Interrupt Unit

This block gives every CPU of a small cluster two inter-processor interrupt channels, named "other" and "self". Each channel has its own pending flag and mask flag. A single write to the send register can raise the "other" channel on any set of CPUs at once. A CPU acknowledges and masks its own channels through a current-CPU register view, selected by the CPU number that comes with the write. A second view, one 128-byte page per CPU, reaches the raise, clear, mask-set and mask-clear functions of any named CPU.

A channel that is pending and unmasked drives the CPU's interrupt request line. When the CPU reads its event register, the block reports the deliverable channel with the highest priority as an event code and masks that channel in the same cycle. The pending flag stays set until software acknowledges it. Software then writes the mask-clear register to accept the next interrupt on that channel. IPI events are held back while the CPU has a hardware interrupt deliverable, so that hardware sources are served first. The page layout supports up to eight CPUs.

Top module: `ipi_unit`

## Requirements
- R1: After reset both channels of every CPU are masked and not pending: `ipi_req` is 0, `evt_data` is 0 and an event read returns 0.
- R2: A write to address 0x010 raises the "other" channel of CPU n for every bit n below NUM_CPU that is 1 in the data. Data bits at or above NUM_CPU have no effect.
- R3: `ipi_req[c]` is 1 exactly when a channel of CPU c is pending and unmasked.
- R4: A read of CPU c's event loads `evt_data` on the next clock edge. Bits [31:24] are 0, bits [23:16] are 4 and bits [15:0] are 1 for "other" or 2 for "self". The value is 0 when no channel of CPU c is deliverable.
- R5: When both channels of a CPU are deliverable, a read reports "other" (number 1). The next read reports "self" (number 2).
- R6: While `hw_irq[c]` is 1, a read of CPU c's event returns 0 and masks nothing.
- R7: A read that reports a channel masks that channel and leaves its pending flag set. A repeated read returns 0 until the channel is unmasked again.
- R8: Address 0x014 is the acknowledge register of the writing CPU. Bit 0 clears that CPU's "other" pending flag and bit 31 clears its "self" pending flag. The other CPUs are not affected.
- R9: Address 0x018 (mask-set) and address 0x01C (mask-clear) act on the writing CPU. In both registers bit 0 selects "other" and bit 31 selects "self". Zero bits have no effect.
- R10: The per-CPU page for CPU k starts at 0x400 + (k << 7). Offset 0x0 raises channels (bit 0 "other", bit 31 "self"), 0x4 clears pending flags, 0x8 sets masks and 0xC clears masks. All of these act on CPU k, whatever the writing CPU is.
- R11: A write to any other address changes no pending or mask flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_cpu | input | CPU_W | CPU issuing the write (selects the current-CPU view) |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Event read strobe |
| rd_cpu | input | CPU_W | CPU whose event register is read |
| hw_irq | input | NUM_CPU | Per CPU: a hardware interrupt is deliverable |
| evt_data | output | 32 | Event code from the most recent read |
| ipi_req | output | NUM_CPU | Per CPU: an IPI channel is deliverable |

## Verification
The bench builds the block with NUM_CPU = 4. With that value all four per-CPU pages are reachable, and send bitmaps carry bits at and above the CPU count. Each channel passes through all four of its states (QUIET, ARMED, HELD, FIRING). The bench covers these cases: both channels of one CPU deliverable at once, a read blocked by a hardware interrupt, and writes to unmapped pages and unmapped local offsets.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int PAGE_SHIFT = 7;
    localparam int PAGE_W     = ADDR_W - PAGE_SHIFT;

    // current-CPU view
    localparam logic [ADDR_W-1:0] LOC_SEND = 12'h010;
    localparam logic [ADDR_W-1:0] LOC_ACK  = 12'h014;
    localparam logic [ADDR_W-1:0] LOC_MSET = 12'h018;
    localparam logic [ADDR_W-1:0] LOC_MCLR = 12'h01C;

    // explicit per-CPU pages: base + (cpu << PAGE_SHIFT)
    localparam logic [ADDR_W-1:0] PCPU_BASE  = 12'h400;
    localparam int                PCPU_PAGE0 = int'(PCPU_BASE >> PAGE_SHIFT);

    localparam logic [PAGE_SHIFT-1:0] OFF_RAISE = 7'h00;
    localparam logic [PAGE_SHIFT-1:0] OFF_CLEAR = 7'h04;
    localparam logic [PAGE_SHIFT-1:0] OFF_MSET  = 7'h08;
    localparam logic [PAGE_SHIFT-1:0] OFF_MCLR  = 7'h0C;

    localparam int BIT_OTHER = 0;
    localparam int BIT_SELF  = 31;

    localparam logic [7:0]  EVT_TYPE_IPI  = 8'd4;
    localparam logic [15:0] EVT_NUM_OTHER = 16'd1;
    localparam logic [15:0] EVT_NUM_SELF  = 16'd2;

    typedef enum logic [1:0] {
        CH_QUIET,   // not pending, masked
        CH_ARMED,   // not pending, unmasked
        CH_HELD,    // pending, masked
        CH_FIRING   // pending, unmasked
    } ch_state_e;

    function automatic logic [DATA_W-1:0] ipi_event(input logic [15:0] num);
        return {8'h00, EVT_TYPE_IPI, num};
    endfunction

endpackage

// File: rtl/ipi_chan_fsm.sv
module ipi_chan_fsm
    import ipi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic drop,
    input  logic hide,
    input  logic reveal,
    input  logic take,
    output logic pending,
    output logic masked,
    output logic deliverable
);

    ch_state_e st_q, st_d;
    logic      pend_nx, mask_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_QUIET;
        else        st_q <= st_d;
    end

    // outputs decoded from the current state
    always_comb begin
        pending     = 1'b0;
        masked      = 1'b1;
        deliverable = 1'b0;
        unique case (st_q)
            CH_QUIET:  begin pending = 1'b0; masked = 1'b1; end
            CH_ARMED:  begin pending = 1'b0; masked = 1'b0; end
            CH_HELD:   begin pending = 1'b1; masked = 1'b1; end
            CH_FIRING: begin pending = 1'b1; masked = 1'b0; deliverable = 1'b1; end
        endcase
    end

    // raise beats drop; an event take beats a mask-clear in the same cycle
    always_comb begin
        pend_nx = raise | (pending & ~drop);
        mask_nx = take | hide | (masked & ~reveal);
        st_d    = st_q;
        unique case ({pend_nx, mask_nx})
            2'b00: st_d = CH_ARMED;
            2'b01: st_d = CH_QUIET;
            2'b10: st_d = CH_FIRING;
            2'b11: st_d = CH_HELD;
        endcase
    end

endmodule

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
    import ipi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               wr_en,
    input  logic [CPU_W-1:0]   wr_cpu,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [NUM_CPU-1:0] raise_oth,
    output logic [NUM_CPU-1:0] raise_slf,
    output logic [NUM_CPU-1:0] drop_oth,
    output logic [NUM_CPU-1:0] drop_slf,
    output logic [NUM_CPU-1:0] hide_oth,
    output logic [NUM_CPU-1:0] hide_slf,
    output logic [NUM_CPU-1:0] reveal_oth,
    output logic [NUM_CPU-1:0] reveal_slf
);

    logic [PAGE_SHIFT-1:0] offs;
    logic                  b_oth, b_slf;
    logic                  is_send, is_ack, is_mset, is_mclr;
    logic                  unused_data;

    assign offs    = wr_addr[PAGE_SHIFT-1:0];
    assign b_oth   = wr_data[BIT_OTHER];
    assign b_slf   = wr_data[BIT_SELF];
    assign is_send = wr_en && (wr_addr == LOC_SEND);
    assign is_ack  = wr_en && (wr_addr == LOC_ACK);
    assign is_mset = wr_en && (wr_addr == LOC_MSET);
    assign is_mclr = wr_en && (wr_addr == LOC_MCLR);
    assign unused_data = ^wr_data;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic mine, page;
        assign mine = (wr_cpu == CPU_W'(c));
        assign page = wr_en &&
                      (wr_addr[ADDR_W-1:PAGE_SHIFT] == PAGE_W'(PCPU_PAGE0 + c));

        assign raise_oth[c]  = (is_send && wr_data[c]) ||
                               (page && offs == OFF_RAISE && b_oth);
        assign raise_slf[c]  = page && offs == OFF_RAISE && b_slf;
        assign drop_oth[c]   = (is_ack && mine && b_oth) ||
                               (page && offs == OFF_CLEAR && b_oth);
        assign drop_slf[c]   = (is_ack && mine && b_slf) ||
                               (page && offs == OFF_CLEAR && b_slf);
        assign hide_oth[c]   = (is_mset && mine && b_oth) ||
                               (page && offs == OFF_MSET && b_oth);
        assign hide_slf[c]   = (is_mset && mine && b_slf) ||
                               (page && offs == OFF_MSET && b_slf);
        assign reveal_oth[c] = (is_mclr && mine && b_oth) ||
                               (page && offs == OFF_MCLR && b_oth);
        assign reveal_slf[c] = (is_mclr && mine && b_slf) ||
                               (page && offs == OFF_MCLR && b_slf);
    end

endmodule

// File: rtl/ipi_evt_sel.sv
module ipi_evt_sel
    import ipi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               rd_en,
    input  logic [CPU_W-1:0]   rd_cpu,
    input  logic [NUM_CPU-1:0] hw_irq,
    input  logic [NUM_CPU-1:0] dlv_oth,
    input  logic [NUM_CPU-1:0] dlv_slf,
    output logic [NUM_CPU-1:0] take_oth,
    output logic [NUM_CPU-1:0] take_slf,
    output logic [DATA_W-1:0]  code
);

    always_comb begin
        take_oth = '0;
        take_slf = '0;
        code     = '0;
        if (rd_en && !hw_irq[rd_cpu]) begin
            if (dlv_oth[rd_cpu]) begin
                take_oth[rd_cpu] = 1'b1;
                code             = ipi_event(EVT_NUM_OTHER);
            end else if (dlv_slf[rd_cpu]) begin
                take_slf[rd_cpu] = 1'b1;
                code             = ipi_event(EVT_NUM_SELF);
            end
        end
    end

endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
    import ipi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CPU_W-1:0]   wr_cpu,
    input  logic [11:0]        wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    input  logic [CPU_W-1:0]   rd_cpu,
    input  logic [NUM_CPU-1:0] hw_irq,
    output logic [31:0]        evt_data,
    output logic [NUM_CPU-1:0] ipi_req
);

    logic [NUM_CPU-1:0] raise_oth, raise_slf, drop_oth, drop_slf;
    logic [NUM_CPU-1:0] hide_oth, hide_slf, reveal_oth, reveal_slf;
    logic [NUM_CPU-1:0] take_oth, take_slf;
    logic [NUM_CPU-1:0] pend_oth, pend_slf, mask_oth, mask_slf;
    logic [NUM_CPU-1:0] dlv_oth, dlv_slf;
    logic [DATA_W-1:0]  evt_code;

    ipi_wr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .wr_en      (wr_en),
        .wr_cpu     (wr_cpu),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .raise_oth  (raise_oth),
        .raise_slf  (raise_slf),
        .drop_oth   (drop_oth),
        .drop_slf   (drop_slf),
        .hide_oth   (hide_oth),
        .hide_slf   (hide_slf),
        .reveal_oth (reveal_oth),
        .reveal_slf (reveal_slf)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        ipi_chan_fsm u_oth (
            .clk         (clk),
            .rst_n       (rst_n),
            .raise       (raise_oth[c]),
            .drop        (drop_oth[c]),
            .hide        (hide_oth[c]),
            .reveal      (reveal_oth[c]),
            .take        (take_oth[c]),
            .pending     (pend_oth[c]),
            .masked      (mask_oth[c]),
            .deliverable (dlv_oth[c])
        );
        ipi_chan_fsm u_slf (
            .clk         (clk),
            .rst_n       (rst_n),
            .raise       (raise_slf[c]),
            .drop        (drop_slf[c]),
            .hide        (hide_slf[c]),
            .reveal      (reveal_slf[c]),
            .take        (take_slf[c]),
            .pending     (pend_slf[c]),
            .masked      (mask_slf[c]),
            .deliverable (dlv_slf[c])
        );
        assign ipi_req[c] = dlv_oth[c] | dlv_slf[c];
    end

    ipi_evt_sel #(.NUM_CPU(NUM_CPU)) u_sel (
        .rd_en    (rd_en),
        .rd_cpu   (rd_cpu),
        .hw_irq   (hw_irq),
        .dlv_oth  (dlv_oth),
        .dlv_slf  (dlv_slf),
        .take_oth (take_oth),
        .take_slf (take_slf),
        .code     (evt_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     evt_data <= '0;
        else if (rd_en) evt_data <= evt_code;
    end

endmodule

// File: rtl/ipi_unit_chk.sv
module ipi_unit_chk
    import ipi_pkg::*;
#(
    parameter  int NUM_CPU = 4,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [CPU_W-1:0]   wr_cpu,
    input logic [11:0]        wr_addr,
    input logic [31:0]        wr_data,
    input logic               rd_en,
    input logic [CPU_W-1:0]   rd_cpu,
    input logic [NUM_CPU-1:0] hw_irq,
    input logic [31:0]        evt_data,
    input logic [NUM_CPU-1:0] ipi_req,
    input logic [NUM_CPU-1:0] pend_oth,
    input logic [NUM_CPU-1:0] mask_oth,
    input logic [NUM_CPU-1:0] dlv_oth
);

    logic unused_chk;
    assign unused_chk = ^wr_data;

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ipi_req == '0 && evt_data == '0));

    a_r2_send_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LOC_SEND && wr_data[0]) |=> pend_oth[0]);

    a_r4_event_format: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_data != '0) |-> (evt_data[31:24] == 8'h00 && evt_data[23:16] == EVT_TYPE_IPI &&
                              (evt_data[15:0] == EVT_NUM_OTHER || evt_data[15:0] == EVT_NUM_SELF)));

    a_r5_other_first: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hw_irq[rd_cpu] && dlv_oth[rd_cpu]) |=> (evt_data == ipi_event(EVT_NUM_OTHER)));

    a_r6_hw_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hw_irq[rd_cpu]) |=> (evt_data == '0 && $stable(ipi_req)));

    a_r7_auto_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hw_irq[rd_cpu] && dlv_oth[rd_cpu]) |=> mask_oth[$past(rd_cpu)]);

    a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == LOC_ACK && wr_data[0]) |=> !pend_oth[$past(wr_cpu)]);

endmodule

bind ipi_unit ipi_unit_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_cpu   (wr_cpu),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_cpu   (rd_cpu),
    .hw_irq   (hw_irq),
    .evt_data (evt_data),
    .ipi_req  (ipi_req),
    .pend_oth (pend_oth),
    .mask_oth (mask_oth),
    .dlv_oth  (dlv_oth)
);

// File: tb/ipi_unit_bench.sv
`timescale 1ns/1ps
module ipi_unit_bench;

    localparam int NCPU = 4;
    localparam int NV   = 27;

    // fields: tag[91:88] op[87:84] (0 write, 1 read) cpu[83:80] addr[79:68]
    //         data[67:36] exp_req[35:32] exp_evt[31:0]
    localparam logic [91:0] VEC [NV] = '{
        {4'd2,  4'd0, 4'd0, 12'h010, 32'h0000_000A, 4'b0000, 32'h0},          // R2 send to 1,3 (masked)
        {4'd9,  4'd0, 4'd1, 12'h01C, 32'h0000_0001, 4'b0010, 32'h0},          // R9 unmask own other
        {4'd3,  4'd0, 4'd3, 12'h01C, 32'h8000_0001, 4'b1010, 32'h0},          // R3
        {4'd4,  4'd1, 4'd3, 12'h000, 32'h0,         4'b0010, 32'h0004_0001},  // R4 read other
        {4'd7,  4'd1, 4'd3, 12'h000, 32'h0,         4'b0010, 32'h0},          // R7 masked now
        {4'd8,  4'd0, 4'd3, 12'h014, 32'h0000_0001, 4'b0010, 32'h0},          // R8 ack
        {4'd8,  4'd0, 4'd3, 12'h01C, 32'h0000_0001, 4'b0010, 32'h0},          // R8 nothing left
        {4'd10, 4'd0, 4'd0, 12'h500, 32'h8000_0001, 4'b0010, 32'h0},          // R10 raise cpu2 both
        {4'd10, 4'd0, 4'd0, 12'h50C, 32'h8000_0001, 4'b0110, 32'h0},          // R10 unmask cpu2
        {4'd5,  4'd1, 4'd2, 12'h000, 32'h0,         4'b0110, 32'h0004_0001},  // R5 other first
        {4'd5,  4'd1, 4'd2, 12'h000, 32'h0,         4'b0010, 32'h0004_0002},  // R5 then self
        {4'd10, 4'd0, 4'd0, 12'h504, 32'h8000_0001, 4'b0010, 32'h0},          // R10 clear cpu2
        {4'd10, 4'd0, 4'd0, 12'h50C, 32'h8000_0001, 4'b0010, 32'h0},          // R10 unmask: none pending
        {4'd11, 4'd0, 4'd2, 12'h7F0, 32'hFFFF_FFFF, 4'b0010, 32'h0},          // R11 unmapped page
        {4'd11, 4'd0, 4'd2, 12'h020, 32'hFFFF_FFFF, 4'b0010, 32'h0},          // R11 unmapped local
        {4'd2,  4'd0, 4'd1, 12'h010, 32'hFFFF_FFF0, 4'b0010, 32'h0},          // R2 high bits ignored
        {4'd9,  4'd0, 4'd1, 12'h018, 32'h0000_0001, 4'b0000, 32'h0},          // R9 mask set
        {4'd9,  4'd0, 4'd1, 12'h01C, 32'h8000_0000, 4'b0000, 32'h0},          // R9 self unmask only
        {4'd10, 4'd0, 4'd1, 12'h480, 32'h8000_0000, 4'b0010, 32'h0},          // R10 raise self
        {4'd7,  4'd1, 4'd1, 12'h000, 32'h0,         4'b0000, 32'h0004_0002},  // R7 self taken
        {4'd7,  4'd1, 4'd1, 12'h000, 32'h0,         4'b0000, 32'h0},          // R7 repeat gives 0
        {4'd2,  4'd0, 4'd2, 12'h010, 32'h0000_0001, 4'b0001, 32'h0},          // R2 send to cpu0
        {4'd9,  4'd0, 4'd0, 12'h014, 32'h0000_0000, 4'b0001, 32'h0},          // R9 zero ack no effect
        {4'd9,  4'd0, 4'd0, 12'h018, 32'h0000_0000, 4'b0001, 32'h0},          // R9 zero mask-set no effect
        {4'd8,  4'd0, 4'd1, 12'h014, 32'h0000_0001, 4'b0001, 32'h0},          // R8 other cpu ack
        {4'd4,  4'd1, 4'd0, 12'h000, 32'h0,         4'b0000, 32'h0004_0001},  // R4
        {4'd3,  4'd1, 4'd0, 12'h000, 32'h0,         4'b0000, 32'h0}           // R3 nothing deliverable
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_cpu = '0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_cpu = '0;
    logic [3:0]  hw_irq = '0;
    logic [31:0] evt_data;
    logic [3:0]  ipi_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    ipi_unit #(.NUM_CPU(NCPU)) u_ipi_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_cpu(rd_cpu),
        .hw_irq(hw_irq), .evt_data(evt_data), .ipi_req(ipi_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input int tag, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (got !== exp) begin
            errors = errors + 1;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_cpu = cpu; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] cpu);
        @(negedge clk);
        rd_en = 1'b1; rd_cpu = cpu;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(1, "ipi_req after reset", 32'(ipi_req), 32'h0);
        chk(1, "evt_data after reset", evt_data, 32'h0);
        do_rd(2'd0);
        chk(1, "event read after reset", evt_data, 32'h0);
        do_wr(2'd0, 12'h01C, 32'h8000_0001);
        chk(1, "unmask shows nothing pending", 32'(ipi_req), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [91:0] v;
            v = VEC[i];
            if (v[84]) do_rd(v[81:80]);
            else       do_wr(v[81:80], v[79:68], v[67:36]);
            chk(int'(v[91:88]), $sformatf("vector %0d ipi_req", i), 32'(ipi_req), 32'(v[35:32]));
            if (v[84])
                chk(int'(v[91:88]), $sformatf("vector %0d evt_data", i), evt_data, v[31:0]);
        end

        // R6 hardware interrupt holds back IPI events (cpu3 other is unmasked)
        do_wr(2'd1, 12'h010, 32'h0000_0008);
        chk(2, "send to cpu3", 32'(ipi_req), 32'h8);
        hw_irq = 4'b1000;
        do_rd(2'd3);
        chk(6, "evt blocked by hw_irq", evt_data, 32'h0);
        chk(6, "no auto mask while blocked", 32'(ipi_req), 32'h8);
        hw_irq = 4'b0100;
        do_rd(2'd3);
        chk(6, "other cpu hw_irq no effect", evt_data, 32'h0004_0001);
        chk(7, "auto mask after read", 32'(ipi_req), 32'h0);
        hw_irq = 4'b0000;

        // R10 per-CPU mask-set/clear on cpu3 page, written by cpu1
        do_wr(2'd1, 12'h58C, 32'h0000_0001);
        chk(10, "page mask-clear cpu3", 32'(ipi_req), 32'h8);
        do_wr(2'd1, 12'h588, 32'h0000_0001);
        chk(10, "page mask-set cpu3", 32'(ipi_req), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule